// File: doc/BRIEF.md
# Clocked Serial Register-Bus Slave

This block is one node on a serial bus. A bus master drives the bus clock and a data-in line. The node answers on its own data-out line, together with an enable that tells the line driver when the node is talking. Every transfer starts with a 16-bit header, sent most significant bit first: an 8-bit node address, one direction bit (1 means read, 0 means write), and a 7-bit register index. After the header, the node streams 8-bit registers out, or takes them in, starting at the indexed register. The index advances by one after each byte and wraps from 127 to 0. The burst lasts as long as the master keeps clocking. A transfer ends when the bus clock has had no rising edge for `IDLE_CYC` system clock cycles. The node then goes back to waiting for a new header.

The bus clock and data-in are synchronised into the system clock domain, and the bus data is sampled on each synchronised rising edge of the bus clock. The data-out line also changes only just after a bus-clock rising edge, so it stays stable for the master's next rising edge. The bus is paced entirely by the master clock. There is no valid/ready handshake and no back-pressure: every byte that is clocked in or out is accepted. Address 255 is a broadcast. A broadcast write to register 127 does not write a register. Instead it carries a serial number, followed by a new node address. The node whose `SERIAL_W`-bit serial number matches takes the new address.

Top module: `srb_slave`

## Requirements
- R1: A header whose address byte equals the node address and whose direction bit is 1 makes the node drive `bus_dout_en_o` high and shift out the indexed register, most significant bit first. Each bit appears after the bus-clock rising edge that precedes the edge on which the master samples it.
- R2: During a read burst, each further 8 bus clocks return the next register index.
- R3: A write header (direction bit 0) followed by N bytes stores them into the indexed register and the N-1 registers after it.
- R4: Indices at or above `NUM_REGS` read as 8'hFF, and writes to those indices change no register.
- R5: The register index wraps from 127 to 0 within a burst.
- R6: A header for another address leaves `bus_dout_en_o` low for the whole transfer, and the data that follows changes no register.
- R7: A broadcast header (address 255) with direction bit 0 writes registers like a matching write. A broadcast read leaves `bus_dout_en_o` low.
- R8: After `IDLE_CYC` system cycles with no bus-clock rising edge, the node drops `bus_dout_en_o` and the next bit starts a new header, even if the previous header was incomplete.
- R9: A broadcast write to index 127 carries `SERIAL_W/8` serial bytes (most significant first) and then one address byte. If every serial byte equals `serial_num_i`, the node takes that address. Otherwise its address stays unchanged.
- R10: After reset the node address is `DEFAULT_ADDR`, all registers are 0, `bus_dout_en_o` is low and `bus_dout_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serial_num_i | input | SERIAL_W | Unique serial number used for address assignment |
| bus_clk_i | input | 1 | Bus clock from the master |
| bus_din_i | input | 1 | Serial data from the master |
| bus_dout_o | output | 1 | Serial data to the master, high when released |
| bus_dout_en_o | output | 1 | High while the node drives the data-out line |

## Verification
The hardest state to reach is a change of node address. It needs a complete broadcast frame in which every serial byte matches, and its effect only shows up in later transfers. The stimulus first sends a frame with one wrong serial byte and checks that the old address still answers. It then sends the correct frame and checks that the new address answers and the old one is ignored. Index wrap and a header cut short by the idle timeout are also set up by directed frames. Random bursts at random indices, mixed with foreign addresses, exercise the auto-increment against a bench register model.

// File: rtl/srb_pkg.sv
package srb_pkg;
  typedef enum logic [1:0] {ST_HDR, ST_RD, ST_WR, ST_SKIP} srb_state_e;
  localparam logic [7:0] BCAST_ADDR = 8'hFF;
  localparam logic [6:0] ASSIGN_IDX = 7'h7F;
endpackage

// File: rtl/srb_edge_front.sv
module srb_edge_front #(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_CYC    = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_clk_i,
  input  logic bus_din_i,
  output logic rise_o,
  output logic bit_o,
  output logic timeout_o
);
  localparam int TW = $clog2(IDLE_CYC + 1);

  logic [SYNC_STAGES:0]   clk_pipe_q;
  logic [SYNC_STAGES-1:0] din_pipe_q;
  logic [TW-1:0]          tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_pipe_q <= '0;
      din_pipe_q <= '0;
    end else begin
      clk_pipe_q <= {clk_pipe_q[SYNC_STAGES-1:0], bus_clk_i};
      din_pipe_q <= {din_pipe_q[SYNC_STAGES-2:0], bus_din_i};
    end
  end

  assign rise_o = clk_pipe_q[SYNC_STAGES-1] & ~clk_pipe_q[SYNC_STAGES];
  assign bit_o  = din_pipe_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    tmr_q <= TW'(IDLE_CYC);
    else if (rise_o)               tmr_q <= '0;
    else if (tmr_q != TW'(IDLE_CYC)) tmr_q <= tmr_q + 1'b1;
  end

  assign timeout_o = !rise_o && (tmr_q == TW'(IDLE_CYC - 1));

  // R8: one frame reset per idle gap
  p_timeout_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);
endmodule

// File: rtl/srb_reg_bank.sv
module srb_reg_bank #(
  parameter int NUM_REGS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic [6:0] wr_idx_i,
  input  logic [7:0] wr_data_i,
  input  logic [6:0] rd_idx_i,
  output logic [7:0] rd_data_o
);
  logic [7:0] mem_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  mem_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == 7'(g))       mem_q[g] <= wr_data_i;
    end
    // R4: a register only changes when its own index is written
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && wr_idx_i == 7'(g)) |=> $stable(mem_q[g]));
  end

  always_comb begin
    rd_data_o = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx_i == 7'(i)) rd_data_o = mem_q[i];
  end
endmodule

// File: rtl/srb_addr_assign.sv
module srb_addr_assign #(
  parameter int         SERIAL_W     = 32,
  parameter logic [7:0] DEFAULT_ADDR = 8'h5A
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SERIAL_W-1:0] serial_i,
  input  logic                frame_rst_i,
  input  logic                byte_valid_i,
  input  logic [7:0]          byte_i,
  output logic [7:0]          node_addr_o
);
  localparam int SB = SERIAL_W / 8;
  localparam int CW = $clog2(SB + 2);

  logic [CW-1:0] cnt_q;
  logic          match_q;
  logic [7:0]    sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < SB; i++)
      if (cnt_q == CW'(i)) sel = serial_i[8*(SB-1-i) +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      match_q     <= 1'b1;
      node_addr_o <= DEFAULT_ADDR;
    end else if (frame_rst_i) begin
      cnt_q   <= '0;
      match_q <= 1'b1;
    end else if (byte_valid_i) begin
      if (cnt_q < CW'(SB)) begin
        match_q <= match_q && (byte_i == sel);
        cnt_q   <= cnt_q + 1'b1;
      end else if (cnt_q == CW'(SB)) begin
        if (match_q) node_addr_o <= byte_i;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R9: the address only moves on the byte after the serial number
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid_i && cnt_q == CW'(SB)) |=> $stable(node_addr_o));
endmodule

// File: rtl/srb_frame_ctrl.sv
module srb_frame_ctrl
  import srb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise_i,
  input  logic       bit_i,
  input  logic       timeout_i,
  input  logic [7:0] node_addr_i,
  output logic [6:0] rd_idx_o,
  input  logic [7:0] rd_data_i,
  output logic       wr_en_o,
  output logic [6:0] wr_idx_o,
  output logic [7:0] wr_data_o,
  output logic       asg_valid_o,
  output logic       dout_o,
  output logic       dout_en_o
);
  srb_state_e state_q;
  logic [3:0]  hcnt_q;
  logic [14:0] hdr_q;
  logic [2:0]  bcnt_q;
  logic [6:0]  ptr_q;
  logic [7:0]  sh_q;
  logic        asg_q;

  logic [15:0] hdr_full;
  logic        match, bcast, byte_done;

  assign hdr_full  = {hdr_q, bit_i};
  assign match     = hdr_full[15:8] == node_addr_i;
  assign bcast     = hdr_full[15:8] == BCAST_ADDR;
  assign byte_done = rise_i && (bcnt_q == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HDR;
      hcnt_q  <= '0;
      hdr_q   <= '0;
      bcnt_q  <= '0;
      ptr_q   <= '0;
      sh_q    <= '1;
      asg_q   <= 1'b0;
    end else if (timeout_i) begin
      state_q <= ST_HDR;
      hcnt_q  <= '0;
      bcnt_q  <= '0;
    end else if (rise_i) begin
      case (state_q)
        ST_HDR: begin
          hdr_q  <= hdr_full[14:0];
          hcnt_q <= hcnt_q + 1'b1;
          if (hcnt_q == 4'd15) begin
            ptr_q  <= hdr_full[6:0];
            bcnt_q <= '0;
            asg_q  <= bcast && !hdr_full[7] && (hdr_full[6:0] == ASSIGN_IDX);
            if (!(match || bcast))  state_q <= ST_SKIP;
            else if (hdr_full[7]) begin
              if (match && !bcast) begin
                state_q <= ST_RD;
                sh_q    <= rd_data_i;
              end else state_q <= ST_SKIP;
            end else state_q <= ST_WR;
          end
        end
        ST_RD: begin
          bcnt_q <= bcnt_q + 1'b1;
          if (bcnt_q == 3'd7) begin
            ptr_q <= ptr_q + 1'b1;
            sh_q  <= rd_data_i;
          end else sh_q <= {sh_q[6:0], 1'b1};
        end
        ST_WR: begin
          sh_q   <= {sh_q[6:0], bit_i};
          bcnt_q <= bcnt_q + 1'b1;
          if (bcnt_q == 3'd7) ptr_q <= ptr_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign rd_idx_o    = (state_q == ST_HDR) ? hdr_full[6:0] : ptr_q + 1'b1;
  assign wr_idx_o    = ptr_q;
  assign wr_data_o   = {sh_q[6:0], bit_i};
  assign wr_en_o     = (state_q == ST_WR) && byte_done && !asg_q;
  assign asg_valid_o = (state_q == ST_WR) && byte_done && asg_q;
  assign dout_en_o   = (state_q == ST_RD);
  assign dout_o      = dout_en_o ? sh_q[7] : 1'b1;

  // R2/R5: the index steps by one (mod 128) after each read byte
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD && byte_done) |=> ptr_q == $past(ptr_q) + 7'd1);
  // R8: idle timeout releases the data-out line
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_i |=> !dout_en_o);
  // R6: a released line always reads high
  p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en_o |-> dout_o);
endmodule

// File: rtl/srb_slave.sv
module srb_slave #(
  parameter int         NUM_REGS     = 16,
  parameter int         SERIAL_W     = 32,
  parameter logic [7:0] DEFAULT_ADDR = 8'h5A,
  parameter int         IDLE_CYC     = 40,
  parameter int         SYNC_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SERIAL_W-1:0] serial_num_i,
  input  logic                bus_clk_i,
  input  logic                bus_din_i,
  output logic                bus_dout_o,
  output logic                bus_dout_en_o
);
  logic       rise, sbit, timeout;
  logic [7:0] node_addr, rd_data, wr_data;
  logic [6:0] rd_idx, wr_idx;
  logic       wr_en, asg_valid;

  srb_edge_front #(.SYNC_STAGES(SYNC_STAGES), .IDLE_CYC(IDLE_CYC)) front_i (
    .clk(clk), .rst_n(rst_n), .bus_clk_i(bus_clk_i), .bus_din_i(bus_din_i),
    .rise_o(rise), .bit_o(sbit), .timeout_o(timeout));

  srb_frame_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .bit_i(sbit), .timeout_i(timeout),
    .node_addr_i(node_addr), .rd_idx_o(rd_idx), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .asg_valid_o(asg_valid), .dout_o(bus_dout_o), .dout_en_o(bus_dout_en_o));

  srb_reg_bank #(.NUM_REGS(NUM_REGS)) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data));

  srb_addr_assign #(.SERIAL_W(SERIAL_W), .DEFAULT_ADDR(DEFAULT_ADDR)) asg_i (
    .clk(clk), .rst_n(rst_n), .serial_i(serial_num_i), .frame_rst_i(timeout),
    .byte_valid_i(asg_valid), .byte_i(wr_data), .node_addr_o(node_addr));
endmodule

// File: tb/srb_slave_tb_top.sv
module srb_slave_tb_top;
  localparam int         NREG   = 16;
  localparam logic [7:0] DEFA   = 8'h5A;
  localparam logic [31:0] SER   = 32'hC0FFEE42;
  localparam int         HALF   = 5;

  logic clk = 0, rst_n = 0, bclk = 0, bdin = 0;
  logic bdout, bden;
  int   n_run = 0, n_fail = 0;
  bit   finished = 0;
  logic [7:0] model [128];
  logic [7:0] node_m;
  logic [7:0] buf_b [8];

  always #10 clk = ~clk;

  srb_slave #(.NUM_REGS(NREG), .SERIAL_W(32), .DEFAULT_ADDR(DEFA), .IDLE_CYC(40))
    dut_i (.clk(clk), .rst_n(rst_n), .serial_num_i(SER), .bus_clk_i(bclk),
           .bus_din_i(bdin), .bus_dout_o(bdout), .bus_dout_en_o(bden));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_bit(input logic b);
    bdin = b; wait_n(HALF); bclk = 1; wait_n(HALF); bclk = 0;
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) pulse_bit(v[i]);
  endtask

  task automatic gap();
    bdin = 0; wait_n(70);
  endtask

  task automatic rd_byte(output logic [7:0] b, output bit en_all, output bit en_any);
    en_all = 1; en_any = 0;
    for (int i = 7; i >= 0; i--) begin
      bdin = 0; wait_n(HALF);
      b[i] = bdout; en_all &= bden; en_any |= bden;
      bclk = 1; wait_n(HALF); bclk = 0;
    end
  endtask

  function automatic logic [7:0] exp_rd(input int idx);
    return (idx < NREG) ? model[idx] : 8'hFF;
  endfunction

  // write burst of n bytes from buf_b; updates the model per R3/R4/R5/R6/R7
  task automatic do_write(input logic [7:0] a, input logic [6:0] r, input int n);
    send_bits({a, 1'b0, r}, 16);
    for (int k = 0; k < n; k++) begin
      send_bits({8'h00, buf_b[k]}, 8);
      if (a == node_m || a == 8'hFF) begin
        int idx = (int'(r) + k) % 128;
        if (idx < NREG) model[idx] = buf_b[k];
      end
    end
    gap();
  endtask

  task automatic do_read(input logic [7:0] a, input logic [6:0] r, input int n, input string req);
    logic [7:0] b; bit ea, en;
    send_bits({a, 1'b1, r}, 16);
    for (int k = 0; k < n; k++) begin
      int idx = (int'(r) + k) % 128;
      rd_byte(b, ea, en);
      if (a == node_m && a != 8'hFF) begin
        chk(ea, {req, " drive"}, int'(ea), 1);
        chk(b == exp_rd(idx), req, int'(b), int'(exp_rd(idx)));
      end else
        chk(!en, {req, " released"}, int'(en), 0);
    end
    gap();
  endtask

  task automatic do_assign(input logic [31:0] s, input logic [7:0] na);
    send_bits({8'hFF, 1'b0, 7'h7F}, 16);
    for (int k = 3; k >= 0; k--) send_bits({8'h00, s[8*k +: 8]}, 8);
    send_bits({8'h00, na}, 8);
    if (s == SER) node_m = na;
    gap();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    node_m = DEFA;
    void'($urandom(32'h5EED));
    wait_n(5); rst_n = 1; wait_n(5);

    // R10 reset state
    chk(bden == 0, "R10 en", int'(bden), 0);
    chk(bdout == 1, "R10 dout", int'(bdout), 1);
    do_read(DEFA, 7'd0, 2, "R10 regs zero");

    // R1 R2 R3 directed burst
    buf_b[0] = 8'hA5; buf_b[1] = 8'h3C; buf_b[2] = 8'h81;
    do_write(DEFA, 7'd3, 3);
    do_read(DEFA, 7'd3, 3, "R1 R2 R3 burst");

    // R4 out-of-range index
    buf_b[0] = 8'h11; buf_b[1] = 8'h22; buf_b[2] = 8'h33;
    do_write(DEFA, 7'd15, 3);
    do_read(DEFA, 7'd14, 4, "R4 oob");

    // R5 wrap 127 -> 0
    buf_b[0] = 8'h77; buf_b[1] = 8'h5E;
    do_write(DEFA, 7'd127, 2);
    do_read(DEFA, 7'd127, 3, "R5 wrap");

    // R6 foreign address
    buf_b[0] = 8'hEE;
    do_write(8'h21, 7'd2, 1);
    do_read(DEFA, 7'd2, 1, "R6 untouched");
    do_read(8'h21, 7'd2, 2, "R6 foreign read");

    // R7 broadcast
    buf_b[0] = 8'h6B; buf_b[1] = 8'h9D;
    do_write(8'hFF, 7'd5, 2);
    do_read(DEFA, 7'd5, 2, "R7 bcast write");
    do_read(8'hFF, 7'd5, 1, "R7 bcast read");

    // R8 partial header then timeout
    send_bits(16'h001F, 5);
    gap();
    chk(bden == 0, "R8 en", int'(bden), 0);
    do_read(DEFA, 7'd3, 1, "R8 after timeout");

    // R9 wrong serial, then right serial
    do_assign(SER ^ 32'h0000_0100, 8'h33);
    do_read(DEFA, 7'd4, 1, "R9 wrong serial keeps addr");
    do_assign(SER, 8'h33);
    chk(node_m == 8'h33, "R9 model", int'(node_m), 8'h33);
    do_read(8'h33, 7'd4, 1, "R9 new addr");
    do_read(DEFA, 7'd4, 1, "R9 old addr ignored");

    // random bursts (R2 R3 R4 R5 R6)
    for (int t = 0; t < 30; t++) begin
      logic [6:0] r = 7'($urandom_range(0, 127));
      int n = $urandom_range(1, 4);
      logic [7:0] a = ($urandom_range(0, 4) == 0) ? 8'h44 : node_m;
      if ($urandom_range(0, 1) == 1) begin
        for (int k = 0; k < n; k++) buf_b[k] = 8'($urandom);
        do_write(a, r, n);
      end else
        do_read(a, r, n, "R2 random");
    end
    for (int i = 0; i < NREG; i++) do_read(node_m, 7'(i), 1, "R3 final sweep");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule